// File: doc/BRIEF.md
# Sector Ring-Buffer Block Pointer

This block holds the block-number pointers for a ring buffer in external memory. The ring buffer stores sector data and subcode data from an optical disc. There are two pointers, each PTR_W bits wide (9 by default). The data pointer holds the most recent complete decoded data block. The subcode pointer holds the most recent complete subcode block. The host can load either pointer. Each pointer also advances on its own events. Both pointers wrap from the top value back to zero.

From the pointers, the block works out where the incoming material goes:

- **Data target.** The sector now arriving goes to the block after the data pointer. If that sequential number equals a compare value, the sector goes to a separately supplied redirect block for that one sector.
- **Advance policy.** One policy advances the data pointer on every sector sync. The other advances it only when an error check ends with neither error flag set.
- **Subcode target.** Subcode normally goes to the block after the subcode pointer. A select bit makes subcode buffering follow the data pointer instead.

Memory addressing and the correction logic itself sit outside this block.

Top module: `ring_blkptr`

## Requirements
- R1: After a synchronous reset, data_ptr and sub_ptr are 0.
- R2: A pulse on data_ld or sub_ld loads ld_val into that pointer on the next clock edge. A load takes priority over an advance in the same cycle.
- R3: With adv_mode = 0 (advance on sync), data_ptr increments on each cycle where sync_pls is 1. In this mode chk_done has no effect.
- R4: With adv_mode = 1 (advance on clean check), data_ptr increments on a cycle where chk_done is 1 and both stat_err and corr_err are 0. In this mode sync_pls has no effect.
- R5: With adv_mode = 1, a chk_done with stat_err or corr_err set leaves data_ptr unchanged.
- R6: data_tgt is (data_ptr + 1) mod 2^PTR_W. When that value equals cmp_blk, data_tgt is redir_blk instead.
- R7: sub_ptr increments on each cycle where sub_end is 1. With sub_follow = 0, sub_tgt is (sub_ptr + 1) mod 2^PTR_W.
- R8: With sub_follow = 1, sub_tgt is (data_ptr + 1) mod 2^PTR_W, without any redirect.
- R9: Both pointers wrap from 2^PTR_W - 1 to 0 when they increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_mode | input | 1 | 0: advance on sync; 1: advance on clean error check |
| sub_follow | input | 1 | 1: subcode target follows the data pointer |
| sync_pls | input | 1 | Sector sync pulse |
| chk_done | input | 1 | End-of-error-check pulse |
| stat_err | input | 1 | Status error flag for the checked sector |
| corr_err | input | 1 | Correction-incomplete flag for the checked sector |
| sub_end | input | 1 | End of buffering for one subcode block |
| data_ld | input | 1 | Host load of the data pointer |
| sub_ld | input | 1 | Host load of the subcode pointer |
| ld_val | input | PTR_W | Value for a host load |
| cmp_blk | input | PTR_W | Block number that triggers the redirect |
| redir_blk | input | PTR_W | Block used in place of the matched block |
| data_ptr | output | PTR_W | Latest complete data block |
| sub_ptr | output | PTR_W | Latest complete subcode block |
| data_tgt | output | PTR_W | Block receiving the current sector |
| sub_tgt | output | PTR_W | Block receiving the current subcode |

## Verification
The assertions treat every event input as a one-cycle qualifier that is sampled only at a clock edge. They also assume the error flags are valid whenever chk_done is high. Beyond that, they assume nothing about how events are spaced, so any mix of sync, check and load pulses is legal.

The stimulus changes inputs only on the falling edge. Event patterns come from counter bits, which walks through every combination of error flags, simultaneous loads and increments. A full sweep of loaded values covers every pointer value, including the wrap point and the redirect match.

// File: rtl/rbp_pkg.sv
package rbp_pkg;

    typedef enum logic {
        ADV_ON_SYNC  = 1'b0,
        ADV_ON_CHECK = 1'b1
    } adv_mode_e;

    typedef struct packed {
        logic load;
        logic step;
    } ptr_ctl_t;

    typedef struct packed {
        logic fired;
        logic stat_bad;
        logic corr_bad;
    } chk_evt_t;

    function automatic logic chk_clean(input chk_evt_t e);
        return e.fired && !e.stat_bad && !e.corr_bad;
    endfunction

endpackage

// File: rtl/rbp_counter.sv
module rbp_counter #(
    parameter int W = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  rbp_pkg::ptr_ctl_t    ctl,
    input  logic [W-1:0]         ld_val,
    output logic [W-1:0]         cnt
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (ctl.load)
            cnt <= ld_val;
        else if (ctl.step)
            cnt <= cnt + ONE;
    end
endmodule

// File: rtl/rbp_adv_sel.sv
module rbp_adv_sel (
    input  rbp_pkg::adv_mode_e mode,
    input  logic               sync_pls,
    input  rbp_pkg::chk_evt_t  chk,
    output logic               step
);
    import rbp_pkg::*;

    always_comb begin
        unique case (mode)
            ADV_ON_SYNC:  step = sync_pls;
            ADV_ON_CHECK: step = chk_clean(chk);
            default:      step = 1'b0;
        endcase
    end
endmodule

// File: rtl/rbp_target.sv
module rbp_target #(
    parameter int W = 9
) (
    input  logic [W-1:0] data_ptr,
    input  logic [W-1:0] sub_ptr,
    input  logic [W-1:0] cmp_blk,
    input  logic [W-1:0] redir_blk,
    input  logic         sub_follow,
    output logic [W-1:0] data_tgt,
    output logic [W-1:0] sub_tgt
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] data_seq;
    logic [W-1:0] sub_seq;

    always_comb begin
        data_seq = data_ptr + ONE;
        sub_seq  = sub_ptr + ONE;
        data_tgt = (data_seq == cmp_blk) ? redir_blk : data_seq;
        sub_tgt  = sub_follow ? data_seq : sub_seq;
    end
endmodule

// File: rtl/ring_blkptr.sv
module ring_blkptr #(
    parameter int PTR_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_mode,
    input  logic             sub_follow,
    input  logic             sync_pls,
    input  logic             chk_done,
    input  logic             stat_err,
    input  logic             corr_err,
    input  logic             sub_end,
    input  logic             data_ld,
    input  logic             sub_ld,
    input  logic [PTR_W-1:0] ld_val,
    input  logic [PTR_W-1:0] cmp_blk,
    input  logic [PTR_W-1:0] redir_blk,
    output logic [PTR_W-1:0] data_ptr,
    output logic [PTR_W-1:0] sub_ptr,
    output logic [PTR_W-1:0] data_tgt,
    output logic [PTR_W-1:0] sub_tgt
);
    import rbp_pkg::*;

    localparam int NPTR = 2;

    chk_evt_t  chk;
    logic      data_step;
    ptr_ctl_t  ctl  [NPTR];
    logic [PTR_W-1:0] cnt [NPTR];

    assign chk = '{fired: chk_done, stat_bad: stat_err, corr_bad: corr_err};

    rbp_adv_sel u_adv (
        .mode     (adv_mode_e'(adv_mode)),
        .sync_pls (sync_pls),
        .chk      (chk),
        .step     (data_step)
    );

    assign ctl[0] = '{load: data_ld, step: data_step};
    assign ctl[1] = '{load: sub_ld,  step: sub_end};

    for (genvar i = 0; i < NPTR; i++) begin : g_ptr
        rbp_counter #(.W(PTR_W)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .ctl    (ctl[i]),
            .ld_val (ld_val),
            .cnt    (cnt[i])
        );
    end

    assign data_ptr = cnt[0];
    assign sub_ptr  = cnt[1];

    rbp_target #(.W(PTR_W)) u_tgt (
        .data_ptr   (data_ptr),
        .sub_ptr    (sub_ptr),
        .cmp_blk    (cmp_blk),
        .redir_blk  (redir_blk),
        .sub_follow (sub_follow),
        .data_tgt   (data_tgt),
        .sub_tgt    (sub_tgt)
    );
endmodule

// File: rtl/ring_blkptr_chk.sv
module ring_blkptr_chk #(
    parameter int PTR_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             adv_mode,
    input logic             sub_follow,
    input logic             sync_pls,
    input logic             chk_done,
    input logic             stat_err,
    input logic             corr_err,
    input logic             sub_end,
    input logic             data_ld,
    input logic             sub_ld,
    input logic [PTR_W-1:0] ld_val,
    input logic [PTR_W-1:0] cmp_blk,
    input logic [PTR_W-1:0] redir_blk,
    input logic [PTR_W-1:0] data_ptr,
    input logic [PTR_W-1:0] sub_ptr,
    input logic [PTR_W-1:0] data_tgt,
    input logic [PTR_W-1:0] sub_tgt
);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (data_ptr == '0 && sub_ptr == '0));

    assert_data_load_R2: assert property (@(posedge clk) disable iff (rst)
        data_ld |=> data_ptr == $past(ld_val));

    assert_sub_load_R2: assert property (@(posedge clk) disable iff (rst)
        sub_ld |=> sub_ptr == $past(ld_val));

    assert_sync_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!adv_mode && sync_pls && !data_ld) |=> data_ptr == PTR_W'($past(data_ptr) + ONE));

    assert_sync_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (!adv_mode && !sync_pls && !data_ld) |=> $stable(data_ptr));

    assert_clean_step_R4: assert property (@(posedge clk) disable iff (rst)
        (adv_mode && chk_done && !stat_err && !corr_err && !data_ld)
        |=> data_ptr == PTR_W'($past(data_ptr) + ONE));

    assert_err_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (adv_mode && (!chk_done || stat_err || corr_err) && !data_ld) |=> $stable(data_ptr));

    assert_redirect_R6: assert property (@(posedge clk) disable iff (rst)
        (PTR_W'(data_ptr + ONE) == cmp_blk) |-> data_tgt == redir_blk);

    assert_sub_step_R7: assert property (@(posedge clk) disable iff (rst)
        (sub_end && !sub_ld) |=> sub_ptr == PTR_W'($past(sub_ptr) + ONE));

    assert_sub_follow_R8: assert property (@(posedge clk) disable iff (rst)
        sub_follow |-> sub_tgt == PTR_W'(data_ptr + ONE));

    assert_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (sub_end && !sub_ld && sub_ptr == '1) |=> sub_ptr == '0);
endmodule

bind ring_blkptr ring_blkptr_chk #(.PTR_W(PTR_W)) u_chk (.*);

// File: tb/ring_blkptr_tb_top.sv
module ring_blkptr_tb_top;
    localparam int W = 9;
    localparam int M = 1 << W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic adv_mode = 0, sub_follow = 0, sync_pls = 0, chk_done = 0;
    logic stat_err = 0, corr_err = 0, sub_end = 0, data_ld = 0, sub_ld = 0;
    logic [W-1:0] ld_val = '0, cmp_blk = '0, redir_blk = '0;
    logic [W-1:0] data_ptr, sub_ptr, data_tgt, sub_tgt;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int dp = 0;
    int sp = 0;

    always #2.5 clk = ~clk;

    ring_blkptr #(.PTR_W(W)) dut_i (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        int dn = (dp + 1) % M;
        chk({req, " data_ptr"}, int'(data_ptr), dp);
        chk({req, " sub_ptr"},  int'(sub_ptr),  sp);
        chk({req, " data_tgt"}, int'(data_tgt), (dn == int'(cmp_blk)) ? int'(redir_blk) : dn);
        chk({req, " sub_tgt"},  int'(sub_tgt),  sub_follow ? dn : (sp + 1) % M);
    endtask

    // Model next state from present inputs, clock once, then compare.
    task automatic step(input string req);
        int ndp = dp;
        int nsp = sp;
        if (data_ld) ndp = int'(ld_val);
        else if (!adv_mode && sync_pls) ndp = (dp + 1) % M;
        else if (adv_mode && chk_done && !stat_err && !corr_err) ndp = (dp + 1) % M;
        if (sub_ld) nsp = int'(ld_val);
        else if (sub_end) nsp = (sp + 1) % M;
        @(negedge clk);
        dp = ndp;
        sp = nsp;
        check_all(req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        dp = 0; sp = 0;
        check_all("R1");

        // R2 R6 R8: load every value, with a competing advance, sweep redirect match
        for (int v = 0; v < M; v++) begin
            data_ld = 1; sync_pls = 1; ld_val = W'(v);
            cmp_blk = (v % 2 == 0) ? W'(v + 1) : W'(v * 7);
            redir_blk = W'(v * 13 + 5);
            sub_follow = v[2];
            step("R2_R6_R8");
        end
        data_ld = 0; sync_pls = 0;

        // R3 R9: advance on sync, chk_done toggling has no effect
        adv_mode = 0; sub_follow = 0; cmp_blk = W'(100); redir_blk = W'(3);
        data_ld = 1; ld_val = W'(500);
        step("R2");
        data_ld = 0;
        for (int i = 0; i < 600; i++) begin
            sync_pls = i[0] | i[3];
            chk_done = i[1];
            stat_err = 0; corr_err = 0;
            step("R3_R9");
        end
        sync_pls = 0; chk_done = 0;

        // R4 R5: advance on clean check only; sync ignored
        adv_mode = 1;
        for (int i = 0; i < 800; i++) begin
            sync_pls = i[0];
            chk_done = i[1] | i[4];
            stat_err = i[2];
            corr_err = i[3];
            data_ld  = (i % 97 == 50);
            ld_val   = W'(i * 3);
            step((i[2] | i[3]) ? "R5" : "R4");
        end
        sync_pls = 0; chk_done = 0; stat_err = 0; corr_err = 0; data_ld = 0;

        // R7 R9 R2: subcode pointer, wrap and load priority
        sub_ld = 1; ld_val = W'(505);
        step("R2");
        sub_ld = 0;
        for (int i = 0; i < 700; i++) begin
            sub_end = i[0] | i[2];
            sub_follow = i[5];
            sub_ld = (i % 131 == 7);
            ld_val = W'(508);
            step("R7_R9");
        end
        sub_end = 0; sub_ld = 0;

        // R1: reset mid-run
        rst = 1;
        @(negedge clk);
        rst = 0;
        dp = 0; sp = 0;
        check_all("R1");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule